// File: doc/BRIEF.md
# Posted CAS Additive Latency Scheduler

This block sits between a memory controller's command front end and the internal column-access logic of a DRAM device model. A READ or WRITE command may be posted early, ahead of the row-to-column delay. The block holds each such command for a programmable additive latency (AL) and then releases it as an internal column command. The block also produces two strobes that mark when read data and write data occupy the data bus. The read strobe starts AL+CL clocks after the command and the write strobe starts one clock earlier. Each strobe lasts for as many clocks as the burst needs.

The configuration inputs are the 3-bit AL code, the CAS latency, the minimum tRCD in clocks and a burst-length select. These inputs are expected to change only while no command is in flight. An invalid configuration raises an error flag, and every command offered while the flag is high is discarded. The pipeline accepts one command per clock and keeps any number of posted commands in order.

Top module: `cas_post_sched`

## Requirements
- R1: While rstN is low and on the first cycle after it is released, intCmdValid, rdWindow and wrWindow are 0.
- R2: Let a command be sampled with cmdValid=1 at clock edge k under a valid configuration. Then intCmdValid is 1 after edge k+AL, with intCmdAddr equal to the command's address and intCmdIsWrite equal to its type (1 = WRITE, 0 = READ). AL is the value of alCode, from 0 to 6.
- R3: A READ sampled at edge k drives rdWindow high starting after edge k+AL+casLat.
- R4: A WRITE sampled at edge k drives wrWindow high starting after edge k+AL+casLat-1.
- R5: Each data window stays high for 2 clocks when burstIs8=0 (burst of 4) and for 4 clocks when burstIs8=1 (burst of 8). Windows from different commands that overlap merge into one high interval.
- R6: Commands offered on consecutive clocks are all released, one per clock, in the order they were accepted. None is dropped or duplicated.
- R7: cfgError is 1, combinationally, whenever any of these holds: alCode is the reserved code 3'b111, AL is greater than trcdMin, or casLat is below 2. A command offered while cfgError is 1 never shows up on intCmdValid, rdWindow or wrWindow.
- R8: With AL=2, casLat=3 and a burst of 4, a READ sampled at edge k gives rdWindow high after edges k+5 and k+6 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | External READ/WRITE command present |
| cmdIsWrite | input | 1 | 1 = WRITE, 0 = READ |
| cmdAddr | input | ADDR_W | Column address of the command |
| alCode | input | 3 | Additive latency code, 0..6 valid, 7 reserved |
| casLat | input | CL_W | CAS latency in clocks |
| trcdMin | input | TRCD_W | Minimum row-to-column delay in clocks |
| burstIs8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| intCmdValid | output | 1 | Internal column command strobe |
| intCmdIsWrite | output | 1 | Type of the internal command |
| intCmdAddr | output | ADDR_W | Address of the internal command |
| rdWindow | output | 1 | Read data occupies the bus |
| wrWindow | output | 1 | Write data occupies the bus |
| cfgError | output | 1 | Configuration invalid; commands are discarded |

## Verification
A stage of the command delay line that holds a wrong value shows up at the ports as a missing, extra or misaddressed intCmdValid pulse. It becomes visible exactly AL clocks after the command was sampled. A wrong tap or a wrong burst counter shifts or stretches rdWindow or wrWindow. The error appears between RL and RL+BL/2 clocks after the command, never later than 17 clocks. The bench's reference model predicts every port on every clock, so any of these faults is reported on the first cycle where it is visible.

// File: rtl/cas_sched_pkg.sv
package cas_sched_pkg;

  // Width of the delay-line tap indices handed from control to datapath.
  localparam int TAP_W = 5;

  typedef struct packed {
    logic             accept;   // command enters the delay lines this cycle
    logic             isWrite;  // type of the accepted command
    logic [TAP_W-1:0] alTap;    // stage of the command line that is released
    logic [TAP_W-1:0] rdTap;    // event stage one clock before read data
    logic [TAP_W-1:0] wrTap;    // event stage one clock before write data
  } sched_strb_t;

endpackage

// File: rtl/cas_sched_ctrl.sv
module cas_sched_ctrl
  import cas_sched_pkg::*;
#(
  parameter int MAX_AL = 6,
  parameter int CL_W   = 3,
  parameter int TRCD_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdIsWrite,
  input  logic [2:0]        alCode,
  input  logic [CL_W-1:0]   casLat,
  input  logic [TRCD_W-1:0] trcdMin,
  input  logic              burstIs8,
  input  logic              rdHit,
  input  logic              wrHit,
  output sched_strb_t       strb,
  output logic              cfgError,
  output logic              rdWindow,
  output logic              wrWindow
);

  localparam int CNT_W = 3;
  localparam int MIN_CL = 2;

  logic [TAP_W-1:0] alExt, clExt, trcdExt, rdLat;
  logic [CNT_W-1:0] burstLen, rdCnt, wrCnt;

  assign alExt   = TAP_W'(alCode);
  assign clExt   = TAP_W'(casLat);
  assign trcdExt = TAP_W'(trcdMin);
  assign rdLat   = alExt + clExt;

  // Reserved code, AL beyond tRCD, or a CAS latency too short to place
  // the write window one clock ahead of the read window.
  assign cfgError = (alExt > TAP_W'(MAX_AL)) || (alExt > trcdExt) ||
                    (clExt < TAP_W'(MIN_CL));

  assign strb.accept  = cmdValid && !cfgError;
  assign strb.isWrite = cmdIsWrite;
  assign strb.alTap   = alExt;
  assign strb.rdTap   = rdLat - TAP_W'(1);
  assign strb.wrTap   = rdLat - TAP_W'(2);

  // Burst of 8 uses 4 clocks, burst of 4 uses 2 clocks.
  assign burstLen = burstIs8 ? CNT_W'(4) : CNT_W'(2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCnt <= '0;
      wrCnt <= '0;
    end else begin
      if (rdHit)              rdCnt <= burstLen;
      else if (rdCnt != '0)   rdCnt <= rdCnt - CNT_W'(1);
      if (wrHit)              wrCnt <= burstLen;
      else if (wrCnt != '0)   wrCnt <= wrCnt - CNT_W'(1);
    end
  end

  assign rdWindow = (rdCnt != '0);
  assign wrWindow = (wrCnt != '0);

  // R3
  rd_window_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdHit |=> rdWindow);

  // R4
  wr_window_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> wrWindow);

  // R5
  bl4_window_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && !burstIs8) |=> rdWindow ##1 rdWindow);

endmodule

// File: rtl/cas_sched_dpath.sv
module cas_sched_dpath
  import cas_sched_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int MAX_AL = 6,
  parameter int MAX_CL = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  sched_strb_t       strb,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              intValid,
  output logic              intWrite,
  output logic [ADDR_W-1:0] intAddr,
  output logic              rdHit,
  output logic              wrHit
);

  localparam int CMD_DEPTH = MAX_AL + 1;
  localparam int EVT_DEPTH = MAX_AL + MAX_CL;

  logic              cmdV [CMD_DEPTH];
  logic              cmdW [CMD_DEPTH];
  logic [ADDR_W-1:0] cmdA [CMD_DEPTH];
  logic [EVT_DEPTH-1:0] rdEvt, wrEvt;

  // Stage 0 captures the accepted command; later stages shift it along.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdV[0] <= 1'b0;
      cmdW[0] <= 1'b0;
      cmdA[0] <= '0;
    end else begin
      cmdV[0] <= strb.accept;
      cmdW[0] <= strb.isWrite;
      cmdA[0] <= cmdAddr;
    end
  end

  for (genvar s = 1; s < CMD_DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmdV[s] <= 1'b0;
        cmdW[s] <= 1'b0;
        cmdA[s] <= '0;
      end else begin
        cmdV[s] <= cmdV[s-1];
        cmdW[s] <= cmdW[s-1];
        cmdA[s] <= cmdA[s-1];
      end
    end
  end

  // Data-bus event lines: one bit per clock since acceptance.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdEvt <= '0;
      wrEvt <= '0;
    end else begin
      rdEvt <= {rdEvt[EVT_DEPTH-2:0], strb.accept && !strb.isWrite};
      wrEvt <= {wrEvt[EVT_DEPTH-2:0], strb.accept &&  strb.isWrite};
    end
  end

  always_comb begin
    intValid = 1'b0;
    intWrite = 1'b0;
    intAddr  = '0;
    for (int i = 0; i < CMD_DEPTH; i++) begin
      if (strb.alTap == TAP_W'(i)) begin
        intValid = cmdV[i];
        intWrite = cmdW[i];
        intAddr  = cmdA[i];
      end
    end
  end

  always_comb begin
    rdHit = 1'b0;
    wrHit = 1'b0;
    for (int i = 0; i < EVT_DEPTH; i++) begin
      if (strb.rdTap == TAP_W'(i)) rdHit = rdEvt[i];
      if (strb.wrTap == TAP_W'(i)) wrHit = wrEvt[i];
    end
  end

  // R7
  blocked_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accept |=> !cmdV[0]);

  // R2
  zero_al_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && strb.alTap == '0) |=> (intValid && intAddr == $past(cmdAddr)));

endmodule

// File: rtl/cas_post_sched.sv
module cas_post_sched
  import cas_sched_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int MAX_AL = 6,
  parameter int CL_W   = 3,
  parameter int TRCD_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdIsWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [2:0]        alCode,
  input  logic [CL_W-1:0]   casLat,
  input  logic [TRCD_W-1:0] trcdMin,
  input  logic              burstIs8,
  output logic              intCmdValid,
  output logic              intCmdIsWrite,
  output logic [ADDR_W-1:0] intCmdAddr,
  output logic              rdWindow,
  output logic              wrWindow,
  output logic              cfgError
);

  localparam int MAX_CL = (1 << CL_W) - 1;

  sched_strb_t strb;
  logic rdHit, wrHit;

  cas_sched_ctrl #(.MAX_AL(MAX_AL), .CL_W(CL_W), .TRCD_W(TRCD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsWrite(cmdIsWrite),
    .alCode(alCode), .casLat(casLat), .trcdMin(trcdMin), .burstIs8(burstIs8),
    .rdHit(rdHit), .wrHit(wrHit), .strb(strb), .cfgError(cfgError),
    .rdWindow(rdWindow), .wrWindow(wrWindow)
  );

  cas_sched_dpath #(.ADDR_W(ADDR_W), .MAX_AL(MAX_AL), .MAX_CL(MAX_CL)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdAddr(cmdAddr),
    .intValid(intCmdValid), .intWrite(intCmdIsWrite), .intAddr(intCmdAddr),
    .rdHit(rdHit), .wrHit(wrHit)
  );

endmodule

// File: tb/sim_cas_post_sched.sv
module sim_cas_post_sched;

  localparam int ADDR_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdIsWrite = 1'b0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [2:0] alCode = 3'd0;
  logic [2:0] casLat = 3'd2;
  logic [2:0] trcdMin = 3'd0;
  logic burstIs8 = 1'b0;
  logic intCmdValid, intCmdIsWrite, rdWindow, wrWindow, cfgError;
  logic [ADDR_W-1:0] intCmdAddr;

  cas_post_sched #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsWrite(cmdIsWrite),
    .cmdAddr(cmdAddr), .alCode(alCode), .casLat(casLat), .trcdMin(trcdMin),
    .burstIs8(burstIs8), .intCmdValid(intCmdValid), .intCmdIsWrite(intCmdIsWrite),
    .intCmdAddr(intCmdAddr), .rdWindow(rdWindow), .wrWindow(wrWindow),
    .cfgError(cfgError)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0, nFail = 0;
  bit checking = 0;

  // reference model state
  int mAl = 0, mCl = 2, mLen = 2;
  bit mErr = 0;
  bit expV[int];
  bit expW[int];
  int expA[int];
  bit expRd[int];
  bit expWr[int];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      bit ev, er, ew;
      ev = expV.exists(cyc);
      er = expRd.exists(cyc);
      ew = expWr.exists(cyc);
      chk(intCmdValid == ev, "R2/R6 intCmdValid", int'(intCmdValid), int'(ev));
      if (ev && intCmdValid) begin
        chk(int'(intCmdAddr) == expA[cyc], "R2/R6 intCmdAddr", int'(intCmdAddr), expA[cyc]);
        chk(intCmdIsWrite == expW[cyc], "R2 intCmdIsWrite", int'(intCmdIsWrite), int'(expW[cyc]));
      end
      chk(rdWindow == er, "R3/R5/R8 rdWindow", int'(rdWindow), int'(er));
      chk(wrWindow == ew, "R4/R5 wrWindow", int'(wrWindow), int'(ew));
      chk(cfgError == mErr, "R7 cfgError", int'(cfgError), int'(mErr));
    end
  end

  task automatic setCfg(input int al, input int cl, input int trcd, input bit bl8);
    @(negedge clk); #2;
    alCode = 3'(al); casLat = 3'(cl); trcdMin = 3'(trcd); burstIs8 = bl8;
    mAl = al; mCl = cl; mLen = bl8 ? 4 : 2;
    mErr = (al > 6) || (al > trcd) || (cl < 2);
    cmdValid = 1'b0;
  endtask

  // Drives one cycle of command input; sampled at edge cyc+1.
  task automatic issue(input bit v, input bit w, input int a);
    @(negedge clk); #2;
    cmdValid = v; cmdIsWrite = w; cmdAddr = ADDR_W'(a);
    if (v && !mErr) begin
      int e, start;
      e = cyc + 1;
      expV[e + mAl] = 1'b1;
      expW[e + mAl] = w;
      expA[e + mAl] = a;
      start = w ? e + mAl + mCl - 1 : e + mAl + mCl;
      for (int j = 0; j < mLen; j++) begin
        if (w) expWr[start + j] = 1'b1;
        else   expRd[start + j] = 1'b1;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(0, 0, 0);
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finishRun();
  end

  initial begin
    int seed;
    seed = 32'h1234_5677;
    setCfg(0, 2, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle during reset
    chk(!intCmdValid && !rdWindow && !wrWindow, "R1 reset outputs",
        int'({intCmdValid, rdWindow, wrWindow}), 0);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1: first cycle after release
    chk(!intCmdValid && !rdWindow && !wrWindow, "R1 after release",
        int'({intCmdValid, rdWindow, wrWindow}), 0);
    checking = 1;

    // R8: reference case AL=2, CL=3, burst of 4, single READ
    setCfg(2, 3, 3, 0);
    issue(1, 0, 10'h05A);
    idle(20);

    // R2/R3/R4/R5: AL=0, CL=2, burst of 8, mixed back-to-back
    setCfg(0, 2, 1, 1);
    issue(1, 1, 1); issue(1, 0, 2); issue(0, 0, 0); issue(1, 1, 3);
    idle(8); issue(1, 0, 4); idle(20);

    // R6: deepest latency, commands on every clock
    setCfg(6, 7, 6, 1);
    for (int i = 0; i < 12; i++) issue(1, i[0], 100 + i);
    idle(30);

    // R2/R5: AL=4, CL=5, burst of 4, pseudo-random traffic
    setCfg(4, 5, 4, 0);
    for (int i = 0; i < 60; i++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
      issue(seed[0] | seed[3], seed[1], (seed >>> 4) & 10'h3FF);
    end
    idle(30);

    // R7: reserved AL code, AL above tRCD, CAS latency below 2
    setCfg(7, 3, 7, 0);
    for (int i = 0; i < 4; i++) issue(1, i[0], 200 + i);
    idle(20);
    setCfg(3, 3, 2, 1);
    for (int i = 0; i < 4; i++) issue(1, i[0], 300 + i);
    idle(20);
    setCfg(1, 1, 3, 0);
    for (int i = 0; i < 4; i++) issue(1, i[0], 400 + i);
    idle(20);

    // R7: valid configuration again, commands flow
    setCfg(1, 4, 3, 1);
    issue(1, 0, 500); issue(1, 1, 501);
    idle(20);

    checking = 0;
    finishRun();
  end

endmodule